// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, through a path of parameterized width. For each direction there is a storage register, loaded from the source bus when that direction's capture strobe rises. There is also a select line for each direction. It decides whether the driven bus gets the live value of the opposite bus or the stored copy. An active-low enable and a direction input decide which bus is driven, if either is. Each tri-state bus is modelled as three vectors: input, output and output-enable.

Everything runs on one system clock. The capture strobes are treated as asynchronous. Each one passes through a two-flop synchronizer and then an edge detector, so holding a strobe high gives exactly one capture. The output data and output enables are registered. A change of enable, direction or select therefore shows up together with its data on a single clock edge, and no intermediate value can appear on a driven bus. Capture does not depend on the enable, direction or select inputs, so both registers can load while the buses are isolated.

Top module: `xcvr_reg_bidir`

## Requirements
- R1: While rst_n is low, both storage registers clear to zero and both output-enable vectors are zero. After reset, reading either register through its select returns zero.
- R2: When oe_n was high at a clock edge, a_oe and b_oe are both all-zero after that edge (isolation).
- R3: When oe_n was low and dir was low at an edge, a_oe is all-ones and b_oe is all-zero after that edge. With sel_ba low, a_out then equals the b_in value sampled at that edge.
- R4: When oe_n was low and dir was high at an edge, b_oe is all-ones and a_oe is all-zero after that edge. With sel_ab low, b_out then equals the a_in value sampled at that edge.
- R5: When a select line is high at an edge, the bus output of that direction takes that direction's stored register contents (sel_ab drives b_out from the A-to-B register; sel_ba drives a_out from the B-to-A register).
- R6: Take the first clock edge that samples a strobe high after it was low as edge 1. The matching register loads the source bus value present at edge 3. The new value reaches the output at edge 4 when its select is high.
- R7: Capture happens whatever the values of oe_n, dir and the selects. Both registers can capture in the same cycle.
- R8: a_oe and b_oe are never non-zero at the same time. Each is always all-ones or all-zero.
- R9: Output data and output enables change only at clock edges. A select or control change made between edges does not alter the outputs until the next edge, and then takes effect in full.
- R10: A strobe held high gives a single capture. Later changes of the source bus do not reach the register until the strobe has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Active-low output enable for both buses |
| dir | input | 1 | 0: drive bus A from the B side; 1: drive bus B from the A side |
| sel_ab | input | 1 | 0: live A to B; 1: stored A-to-B register to B |
| sel_ba | input | 1 | 0: live B to A; 1: stored B-to-A register to A |
| cap_ab | input | 1 | Asynchronous strobe; a rising edge stores bus A |
| cap_ba | input | 1 | Asynchronous strobe; a rising edge stores bus B |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Value driven onto bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Value driven onto bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
The bench moves bus A after the strobe has been synchronized but before the loading edge. A design with the wrong synchronizer depth or edge placement would store the earlier value, or show it one cycle off. The bench holds a strobe high while the source bus changes. A level-sensitive capture would track the bus instead of freezing it. The bench fires both strobes together while the outputs are disabled. A design that gates capture with the enable would leave a register stale. It also checks select switches midway between edges and direction reversals. An unregistered output path would change data between edges, and a mistimed enable decode would briefly drive both buses.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_A    = 2'd1,
    SIDE_B    = 2'd2
  } drive_side_e;

  function automatic drive_side_e decode_side(input logic oe_n, input logic dir);
    drive_side_e s;
    if (oe_n)     s = SIDE_NONE;
    else if (dir) s = SIDE_B;
    else          s = SIDE_A;
    return s;
  endfunction

endpackage

// File: rtl/xcvr_strobe_sync.sv
module xcvr_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fire
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] shift_q;
  logic [DEPTH-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[DEPTH-2:0], strobe};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign fire = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_r;
    if (load) q_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/xcvr_out_stage.sv
module xcvr_out_stage
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_live,
  input  logic [W-1:0] b_live,
  input  logic [W-1:0] store_ab,
  input  logic [W-1:0] store_ba,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  drive_side_e  side;
  logic         a_en_d, b_en_d;
  logic [W-1:0] a_dat_d, b_dat_d;
  logic [W-1:0] a_dat_q, b_dat_q, a_oe_q, b_oe_q;

  always_comb begin
    side    = decode_side(oe_n, dir);
    a_en_d  = (side == SIDE_A);
    b_en_d  = (side == SIDE_B);
    a_dat_d = sel_ba ? store_ba : b_live;
    b_dat_d = sel_ab ? store_ab : a_live;
  end

  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_dat_q[i] <= 1'b0;
        b_dat_q[i] <= 1'b0;
        a_oe_q[i]  <= 1'b0;
        b_oe_q[i]  <= 1'b0;
      end else begin
        a_dat_q[i] <= a_dat_d[i];
        b_dat_q[i] <= b_dat_d[i];
        a_oe_q[i]  <= a_en_d;
        b_oe_q[i]  <= b_en_d;
      end
    end
  end

  assign a_out = a_dat_q;
  assign b_out = b_dat_q;
  assign a_oe  = a_oe_q;
  assign b_oe  = b_oe_q;
endmodule

// File: rtl/xcvr_reg_bidir.sv
module xcvr_reg_bidir #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  logic         cap_ab_fire, cap_ba_fire;
  logic [W-1:0] store_ab_q, store_ba_q;

  xcvr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_ab (
    .clk(clk), .rst_n(rst_n), .strobe(cap_ab), .fire(cap_ab_fire));

  xcvr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_ba (
    .clk(clk), .rst_n(rst_n), .strobe(cap_ba), .fire(cap_ba_fire));

  xcvr_store_reg #(.W(W)) u_store_ab (
    .clk(clk), .rst_n(rst_n), .load(cap_ab_fire), .din(a_in), .q(store_ab_q));

  xcvr_store_reg #(.W(W)) u_store_ba (
    .clk(clk), .rst_n(rst_n), .load(cap_ba_fire), .din(b_in), .q(store_ba_q));

  xcvr_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_live(a_in), .b_live(b_in),
    .store_ab(store_ab_q), .store_ba(store_ba_q),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));
endmodule

// File: rtl/xcvr_reg_bidir_chk.sv
module xcvr_reg_bidir_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         cap_ab_fire,
  input logic         cap_ba_fire,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic [W-1:0] store_ab_q,
  input logic [W-1:0] store_ba_q
);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !((|a_oe) && (|b_oe))); // R8
  AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe == '0 || a_oe == ONES) && (b_oe == '0 || b_oe == ONES)); // R8
  AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(oe_n) |-> (a_oe == '0 && b_oe == '0)); // R2
  AST_DRIVE_A: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!oe_n && !dir) |-> (a_oe == ONES && b_oe == '0)); // R3
  AST_DRIVE_B: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!oe_n && dir) |-> (b_oe == ONES && a_oe == '0)); // R4
  AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!sel_ba) |-> a_out == $past(b_in)); // R3
  AST_STORED_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(sel_ab) |-> b_out == $past(store_ab_q)); // R5
  AST_STORED_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(sel_ba) |-> a_out == $past(store_ba_q)); // R5
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!cap_ab_fire) |-> $stable(store_ab_q)); // R10
  AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!cap_ba_fire) |-> $stable(store_ba_q)); // R10
endmodule

bind xcvr_reg_bidir xcvr_reg_bidir_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
  .sel_ab(sel_ab), .sel_ba(sel_ba),
  .cap_ab_fire(cap_ab_fire), .cap_ba_fire(cap_ba_fire),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
  .b_out(b_out), .b_oe(b_oe),
  .store_ab_q(store_ab_q), .store_ba_q(store_ba_q));

// File: tb/xcvr_reg_bidir_tb_top.sv
module xcvr_reg_bidir_tb_top;
  localparam int W = 8;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n;
  logic oe_n, dir, sel_ab, sel_ba, cap_ab, cap_ba;
  logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xcvr_reg_bidir #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; oe_n = 1'b1; dir = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
    cap_ab = 1'b0; cap_ba = 1'b0; a_in = '0; b_in = '0;
    tick(3);
    chk("R1 a_oe in reset", a_oe, '0);
    chk("R1 b_oe in reset", b_oe, '0);
    rst_n = 1'b1;
    a_in = 8'h5A; b_in = 8'hC3;
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    tick();
    chk("R1 stored A-to-B after reset", b_out, '0);
    dir = 1'b0; sel_ba = 1'b1;
    tick();
    chk("R1 stored B-to-A after reset", a_out, '0);
  endtask

  task automatic t_isolate;
    sel_ab = 1'b0; sel_ba = 1'b0; oe_n = 1'b1; dir = 1'b1;
    tick();
    chk("R2 a_oe isolated", a_oe, '0);
    chk("R2 b_oe isolated", b_oe, '0);
  endtask

  task automatic t_live_b2a;
    oe_n = 1'b0; dir = 1'b0; sel_ba = 1'b0; b_in = 8'h96;
    tick();
    chk("R3 a_oe", a_oe, ONES);
    chk("R3 b_oe", b_oe, '0);
    chk("R3 live B on A", a_out, 8'h96);
    b_in = 8'h01;
    tick();
    chk("R3 live B follows", a_out, 8'h01);
  endtask

  task automatic t_live_a2b;
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; a_in = 8'h7E;
    tick();
    chk("R4 b_oe", b_oe, ONES);
    chk("R4 a_oe", a_oe, '0);
    chk("R4 live A on B", b_out, 8'h7E);
    dir = 1'b0;
    tick();
    chk("R8 turnaround a_oe", a_oe, ONES);
    chk("R8 turnaround b_oe", b_oe, '0);
  endtask

  task automatic t_capture_timing;
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    a_in = 8'h11; cap_ab = 1'b1;
    tick(2);
    a_in = 8'h22;
    tick();
    chk("R6 not yet visible at edge 3", b_out, '0);
    tick();
    chk("R6 value at edge 3 stored", b_out, 8'h22);
  endtask

  task automatic t_strobe_held;
    a_in = 8'h99;
    tick(5);
    chk("R10 held strobe no recapture", b_out, 8'h22);
    cap_ab = 1'b0;
    tick(3);
    chk("R10 low strobe no capture", b_out, 8'h22);
  endtask

  task automatic t_both_disabled;
    oe_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;
    a_in = 8'h3C; b_in = 8'hA5; cap_ab = 1'b1; cap_ba = 1'b1;
    tick(4);
    chk("R7 outputs off during capture", a_oe | b_oe, '0);
    cap_ab = 1'b0; cap_ba = 1'b0; a_in = 8'h00; b_in = 8'hFF;
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    tick();
    chk("R7 A-to-B captured while off", b_out, 8'h3C);
    chk("R5 stored drives B", b_oe, ONES);
    dir = 1'b0; sel_ba = 1'b1;
    tick();
    chk("R7 B-to-A captured same cycle", a_out, 8'hA5);
  endtask

  task automatic t_sel_switch;
    dir = 1'b1; sel_ab = 1'b0; a_in = 8'h44;
    tick();
    chk("R9 live before switch", b_out, 8'h44);
    sel_ab = 1'b1;
    #1;
    chk("R9 no change between edges", b_out, 8'h44);
    @(posedge clk); #1;
    chk("R9 stored after edge", b_out, 8'h3C);
    oe_n = 1'b1;
    #1;
    chk("R9 enable holds between edges", b_oe, ONES);
    @(posedge clk); #1;
    chk("R9 enable drops at edge", b_oe, '0);
    #1;
  endtask

  initial begin
    t_reset();
    t_isolate();
    t_live_b2a();
    t_live_a2b();
    t_capture_timing();
    t_strobe_held();
    t_both_disabled();
    t_sel_switch();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule